// File: doc/BRIEF.md
# Wide Register Snapshot Reader

This block gives a bus master read access to one register that is wider than the bus. The register image is cut into `REG_W/ACC_W` subwords. Each subword has its own read strobe, and each one maps to its own consecutive readback entry. The entries are combined by OR into a single `ACC_W`-bit read data word. The register image is built from a flat field store. Each field can be normal or bit-reversed, and readable or hidden. A field may cross a subword boundary, and then each part shows up in the subword that holds it.

With buffering enabled and more than one subword, the register triggers its own read buffer. A read of subword 0 returns live data. On the same clock edge it captures the whole register image into a snapshot. Reads of subwords 1 and above are then served from that snapshot, so a multi-word read is coherent and needs no extra trigger access. The snapshot controller is a two-state machine. `SNAP_EMPTY` is the state after reset, when the snapshot holds zero. `SNAP_HELD` means a capture has happened. There are three transitions: `SNAP_EMPTY -> SNAP_HELD` on the first capture (T_FIRST_CAPTURE), `SNAP_HELD -> SNAP_HELD` on any later capture (T_RECAPTURE), and a self-loop in either state when there is no capture (T_IDLE). A capture is any read that is not a write and has the subword 0 strobe set. With buffering disabled, or when the access width equals the register width, every subword reads live values.

Top module: `wide_snap_reader`

## Requirements
- R1: Subword i returns register image bits [(i+1)*ACC_W-1 : i*ACC_W]. There are REG_W/ACC_W subwords, and strobe bit i selects subword i.
- R2: The default field table, with each field's value held at store bits [lo..hi], is: A lo 0 hi 7 normal readable; B lo 8 hi 23 reversed readable; C lo 26 hi 29 hidden; D lo 30 hi 45 normal readable; E lo 46 hi 57 reversed readable. A normal readable field puts store bit b at image bit b. Hidden bits and bits 24, 25 and 58..63 read as zero.
- R3: A reversed field puts store bit (lo+hi-b) at image bit b. This also holds when the field is split across subwords (B across 15/16, E across 47/48).
- R4: In buffered mode, a read of subword 0 returns the live image slice in the same cycle.
- R5: In buffered mode, a read of subword i >= 1 returns the snapshot slice, not the live one.
- R6: On the clock edge where rd_strb[0]=1 and rd_is_wr=0, the snapshot loads the full live image.
- R7: The snapshot resets to zero and holds its value on every other edge.
- R8: While rd_is_wr=1, rd_data is zero and no capture takes place.
- R9: rd_data is zero when no strobe is set. When several strobes are set, rd_data is the OR of the selected subword values.
- R10: With BUFFERED=0, every subword returns the live image slice.
- R11: With BUFFERED=1 and ACC_W equal to REG_W, the single subword returns the live image, as an unbuffered register would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strb | input | REG_W/ACC_W | Per-subword access strobe |
| rd_is_wr | input | 1 | Current access is a write (suppresses readback and capture) |
| fld_store | input | REG_W | Live field storage bits |
| rd_data | output | ACC_W | OR-combined readback word |

## Verification
A corrupt snapshot cannot be seen on the subword 0 path, because that path is always live. It shows up only on the first read of an upper subword after the bad capture. The bench therefore changes the field store between the subword 0 read and the upper-word reads, so a stale, missed or spurious load is visible within one access. A wrong bit mapping shows up at once on the live subword. Walking and all-ones store patterns expose crossed, missing or unreversed field bits at the split boundaries, and they expose bits that should read as zero.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    localparam int NFLD = 5;
    localparam int FLD_LO  [NFLD] = '{0, 8, 26, 30, 46};
    localparam int FLD_HI  [NFLD] = '{7, 23, 29, 45, 57};
    localparam bit FLD_REV [NFLD] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam bit FLD_RD  [NFLD] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

    // Store bit feeding image bit b, or -1 when the image bit reads as zero.
    function automatic int bit_src(input int b);
        int s;
        s = -1;
        for (int f = 0; f < NFLD; f++) begin
            if (FLD_RD[f] && b >= FLD_LO[f] && b <= FLD_HI[f]) begin
                s = FLD_REV[f] ? (FLD_LO[f] + FLD_HI[f] - b) : b;
            end
        end
        return s;
    endfunction

    typedef enum logic [0:0] {
        SNAP_EMPTY = 1'b0,
        SNAP_HELD  = 1'b1
    } snap_state_e;

endpackage

// File: rtl/wsr_field_map.sv
module wsr_field_map #(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] fld_store,
    output logic [REG_W-1:0] live_img
);
    import wsr_pkg::*;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        localparam int SRC = bit_src(b);
        if (SRC >= 0 && SRC < REG_W) begin : g_map
            assign live_img[b] = fld_store[SRC];
        end else begin : g_zero
            assign live_img[b] = 1'b0;
        end
    end

endmodule

// File: rtl/wsr_snap_ctrl.sv
module wsr_snap_ctrl #(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [REG_W-1:0] live_img,
    output logic [REG_W-1:0] snap_q,
    output logic             snap_valid
);
    import wsr_pkg::*;

    snap_state_e state_q, state_d;
    logic        snap_load;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_EMPTY;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_EMPTY: if (capture) state_d = SNAP_HELD;   // T_FIRST_CAPTURE
            SNAP_HELD:  state_d = SNAP_HELD;                // T_RECAPTURE / T_IDLE
            default:    state_d = SNAP_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        snap_load  = 1'b0;
        snap_valid = 1'b0;
        unique case (state_q)
            SNAP_EMPTY: snap_load = capture;
            SNAP_HELD: begin
                snap_load  = capture;
                snap_valid = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         snap_q <= '0;
        else if (snap_load) snap_q <= live_img;
    end

endmodule

// File: rtl/wsr_subword_mux.sv
module wsr_subword_mux #(
    parameter int REG_W       = 64,
    parameter int ACC_W       = 16,
    parameter bit SELF_BYPASS = 1'b1,
    localparam int NSUB       = REG_W / ACC_W
) (
    input  logic [NSUB-1:0]  rd_strb,
    input  logic             rd_is_wr,
    input  logic [REG_W-1:0] live_img,
    input  logic [REG_W-1:0] snap_q,
    input  logic             snap_valid,
    output logic [ACC_W-1:0] rd_data
);
    logic [ACC_W-1:0] entry [NSUB];

    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        logic [ACC_W-1:0] src;
        if (SELF_BYPASS && i > 0) begin : g_buf
            assign src = snap_valid ? snap_q[i*ACC_W +: ACC_W] : '0;
        end else begin : g_live
            assign src = live_img[i*ACC_W +: ACC_W];
        end
        assign entry[i] = (rd_strb[i] && !rd_is_wr) ? src : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSUB; i++) rd_data = rd_data | entry[i];
    end

endmodule

// File: rtl/wide_snap_reader.sv
module wide_snap_reader #(
    parameter int REG_W    = 64,
    parameter int ACC_W    = 16,
    parameter bit BUFFERED = 1'b1,
    localparam int NSUB    = REG_W / ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSUB-1:0]  rd_strb,
    input  logic             rd_is_wr,
    input  logic [REG_W-1:0] fld_store,
    output logic [ACC_W-1:0] rd_data
);
    localparam bit SELF_BYPASS = BUFFERED && (NSUB > 1);

    logic [REG_W-1:0] live_img;
    logic [REG_W-1:0] snap_q;
    logic             snap_valid;

    wsr_field_map #(.REG_W(REG_W)) map_i (
        .fld_store (fld_store),
        .live_img  (live_img)
    );

    if (SELF_BYPASS) begin : g_snap
        logic capture;
        assign capture = rd_strb[0] && !rd_is_wr;
        wsr_snap_ctrl #(.REG_W(REG_W)) ctrl_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .capture    (capture),
            .live_img   (live_img),
            .snap_q     (snap_q),
            .snap_valid (snap_valid)
        );
    end else begin : g_nosnap
        assign snap_q     = '0;
        assign snap_valid = 1'b0;
    end

    wsr_subword_mux #(
        .REG_W       (REG_W),
        .ACC_W       (ACC_W),
        .SELF_BYPASS (SELF_BYPASS)
    ) mux_i (
        .rd_strb    (rd_strb),
        .rd_is_wr   (rd_is_wr),
        .live_img   (live_img),
        .snap_q     (snap_q),
        .snap_valid (snap_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
    parameter int REG_W       = 64,
    parameter int ACC_W       = 16,
    parameter bit SELF_BYPASS = 1'b1,
    localparam int NSUB       = REG_W / ACC_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NSUB-1:0]  rd_strb,
    input logic             rd_is_wr,
    input logic [REG_W-1:0] live_img,
    input logic [REG_W-1:0] snap_q,
    input logic [ACC_W-1:0] rd_data
);
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strb == '0) |-> (rd_data == '0));

    assert_write_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_is_wr |-> (rd_data == '0));

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strb[0] && !rd_is_wr) |=> $stable(snap_q));

    assert_sub0_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_strb == NSUB'(1)) && !rd_is_wr) |-> (rd_data == live_img[ACC_W-1:0]));

    if (SELF_BYPASS) begin : g_buf
        assert_snap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_strb[0] && !rd_is_wr) |=> (snap_q == $past(live_img)));

        assert_upper_snap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_strb == NSUB'(2)) && !rd_is_wr) |-> (rd_data == snap_q[2*ACC_W-1:ACC_W]));
    end else if (NSUB > 1) begin : g_plain
        assert_upper_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_strb == NSUB'(2)) && !rd_is_wr) |-> (rd_data == live_img[2*ACC_W-1:ACC_W]));
    end

endmodule

bind wide_snap_reader wsr_checker #(
    .REG_W       (REG_W),
    .ACC_W       (ACC_W),
    .SELF_BYPASS (SELF_BYPASS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_strb  (rd_strb),
    .rd_is_wr (rd_is_wr),
    .live_img (live_img),
    .snap_q   (snap_q),
    .rd_data  (rd_data)
);

// File: tb/wide_snap_reader_tb_top.sv
module wide_snap_reader_tb_top;
    import wsr_pkg::*;

    localparam int RW = 64;
    localparam int AW = 16;
    localparam int NS = RW / AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] strb = '0;
    logic          wide_s = 1'b0;
    logic          wr = 1'b0;
    logic [RW-1:0] store = '0;
    logic [AW-1:0] q_buf, q_plain;
    logic [RW-1:0] q_wide;

    always #4 clk = ~clk;

    wide_snap_reader #(.REG_W(RW), .ACC_W(AW), .BUFFERED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_strb(strb), .rd_is_wr(wr),
        .fld_store(store), .rd_data(q_buf));

    wide_snap_reader #(.REG_W(RW), .ACC_W(AW), .BUFFERED(1'b0)) dut_plain_i (
        .clk(clk), .rst_n(rst_n), .rd_strb(strb), .rd_is_wr(wr),
        .fld_store(store), .rd_data(q_plain));

    wide_snap_reader #(.REG_W(RW), .ACC_W(RW), .BUFFERED(1'b1)) dut_wide_i (
        .clk(clk), .rst_n(rst_n), .rd_strb(wide_s), .rd_is_wr(wr),
        .fld_store(store), .rd_data(q_wide));

    typedef struct {
        logic [AW-1:0] e_buf;
        logic [AW-1:0] e_plain;
        logic [RW-1:0] e_wide;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    int            n_checks = 0;
    int            n_errors = 0;
    bit            finished = 0;
    logic [RW-1:0] model_snap = '0;

    // Expected image from the field table, built per field and offset (R2, R3)
    function automatic logic [RW-1:0] image_of(input logic [RW-1:0] s);
        logic [RW-1:0] im;
        im = '0;
        for (int f = 0; f < NFLD; f++) begin
            if (FLD_RD[f]) begin
                for (int k = 0; k <= FLD_HI[f] - FLD_LO[f]; k++) begin
                    if (FLD_REV[f]) im[FLD_LO[f] + k] = s[FLD_HI[f] - k];
                    else            im[FLD_LO[f] + k] = s[FLD_LO[f] + k];
                end
            end
        end
        return im;
    endfunction

    task automatic drive(input logic [NS-1:0] st, input logic ws, input logic w,
                         input logic [RW-1:0] s, input string tag);
        exp_t          e;
        logic [RW-1:0] im;
        @(negedge clk);
        strb = st; wide_s = ws; wr = w; store = s;
        im = image_of(s);
        e.e_buf = '0; e.e_plain = '0;
        for (int i = 0; i < NS; i++) begin
            if (st[i] && !w) begin
                e.e_plain |= im[i*AW +: AW];
                e.e_buf   |= (i == 0) ? im[i*AW +: AW] : model_snap[i*AW +: AW];
            end
        end
        e.e_wide = (ws && !w) ? im : '0;
        e.tag = tag;
        sb_q.push_back(e);
        if (st[0] && !w) model_snap = im;   // R6: loads on the following edge
    endtask

    // Monitor: compares each expected item in the middle of its cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks += 3;
                if (q_buf !== e.e_buf) begin
                    n_errors++;
                    $display("FAIL %s buffered: got %h expected %h", e.tag, q_buf, e.e_buf);
                end
                if (q_plain !== e.e_plain) begin
                    n_errors++;
                    $display("FAIL %s R10 unbuffered: got %h expected %h", e.tag, q_plain, e.e_plain);
                end
                if (q_wide !== e.e_wide) begin
                    n_errors++;
                    $display("FAIL %s R11 full-width: got %h expected %h", e.tag, q_wide, e.e_wide);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: snapshot is zero after reset, upper words read zero
        drive(4'b0010, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R7 reset snapshot word1");
        drive(4'b1000, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R7 reset snapshot word3");
        drive(4'b0000, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 all-ones hidden bits zero");
        drive(4'b0000, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, "R9 no strobe");
        // R4/R5/R6: coherent read while the store changes
        a = 64'h0123_4567_89AB_CDEF;
        b = 64'hFEDC_BA98_7654_3210;
        drive(4'b0001, 1'b1, 1'b0, a, "R4 live word0 capture");
        drive(4'b0010, 1'b0, 1'b0, b, "R5 word1 from snapshot");
        drive(4'b0100, 1'b0, 1'b0, b, "R5 word2 from snapshot");
        drive(4'b1000, 1'b1, 1'b0, b, "R5 word3 from snapshot");
        // R8: write with word0 strobe neither reads nor captures
        drive(4'b0001, 1'b1, 1'b1, b, "R8 write zero");
        drive(4'b0010, 1'b0, 1'b0, b, "R8 no capture on write");
        drive(4'b1111, 1'b1, 1'b1, b, "R8 write all strobes");
        // R9: several strobes OR together
        drive(4'b0110, 1'b0, 1'b0, b, "R9 or of words1,2");
        drive(4'b1111, 1'b1, 1'b0, a, "R9 all strobes with capture");
        drive(4'b0010, 1'b0, 1'b0, b, "R6 recapture word1");
        // R3/R1: walking ones through split reversed fields
        for (int k = 0; k < RW; k++) begin
            drive(4'b0001, 1'b1, 1'b0, 64'h1 << k, "R1 R3 walk word0");
            drive(4'b1110, 1'b0, 1'b0, 64'h0, "R3 walk upper from snapshot");
        end
        // Randomised mix
        for (int n = 0; n < 400; n++) begin
            drive(NS'($urandom), 1'($urandom), ($urandom % 5) == 0,
                  {$urandom, $urandom}, "R1 R6 random");
        end
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule